// File: doc/BRIEF.md
# Frame Base Shadow Register with Update Interrupt

This block holds the start address of the frame buffer that a raster display controller scans out. Software writes a new address into a pending register through a simple single-cycle register bus. The scan-out engine keeps using the active address until the timing generator signals the start of a frame. At that boundary the pending address is copied into the active address, so a frame never shows parts of two buffers.

Each copy sets a status bit that records a base-address take-up. An enable mask gates that bit onto a single registered interrupt line. Because the bit is set when the new buffer actually goes into use, and not when software writes it, the interrupt serves as the vertical-blank notification for page flipping. Software reads the masked status to find out whether the interrupt came from this block. It then clears the bits it saw by writing the same value to a write-one-to-clear offset.

Top module: `fbase_shadow`

## Requirements
- R1: After reset the active base, pending base, enable and status all read zero, `irq` is low, and no write is pending. A `frame_start` pulse with no write since reset changes nothing.
- R2: A write at offset 0 stores the pending base with bits [1:0] forced to zero. A read at offset 0 returns the stored value.
- R3: On the first clock with `frame_start` high after a pending-base write, the pending value moves into the active base and status bit 0 is set. Both are visible in the following cycle at offset 1, offset 3 and the `active_base` port.
- R4: A `frame_start` pulse with no pending write outstanding leaves the active base and the status unchanged.
- R5: If a pending-base write and `frame_start` fall in the same cycle, the previously pending value is taken. The newly written value stays pending until the next `frame_start`.
- R6: Offset 2 is the enable mask, and only bit 0 is implemented. Offset 4 reads raw status AND enable, so writing 0 to offset 2 makes offset 4 read zero.
- R7: Writing to offset 5 clears exactly the status bits written as one. Writing zero there leaves the status unchanged.
- R8: If a status set and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: `irq` equals the OR of the masked status bits, delayed by one clock.
- R10: Offset 5 and offsets 6 and 7 read zero. Writes to offsets 1, 3, 4, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle frame boundary pulse from the timing generator |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| active_base | output | DATA_W | Base address in use by scan-out |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of events can fall in the same clock. A frame-boundary take-up can coincide with a status-clear write, and it can also coincide with a new pending-base write. The bench raises `frame_start` in the same cycle as each write. For the clear, it judges that status bit 0 and `irq` stay set. For the pending write, it judges that the older address becomes active and that the newer one appears only after one more frame pulse.

// File: rtl/fbase_shadow.sv
module fbase_shadow #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] active_base,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_PEND = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_ACT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_RAW  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_MSK  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(5);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'(3);

  logic [DATA_W-1:0] pend_base, act_base;
  logic pend_flag, raw_stat, irq_en, irq_q;

  wire wr_pend = bus_we && (bus_addr == OFS_PEND);
  wire wr_en   = bus_we && (bus_addr == OFS_EN);
  wire wr_clr  = bus_we && (bus_addr == OFS_CLR);
  wire take    = frame_start && pend_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_base <= '0;
      act_base  <= '0;
      pend_flag <= 1'b0;
      raw_stat  <= 1'b0;
      irq_en    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_pend) pend_base <= bus_wdata & ALIGN_MASK;
      if (wr_pend) pend_flag <= 1'b1;
      else if (take) pend_flag <= 1'b0;
      if (take) act_base <= pend_base;
      if (wr_en) irq_en <= bus_wdata[0];
      if (take) raw_stat <= 1'b1;
      else if (wr_clr && bus_wdata[0]) raw_stat <= 1'b0;
      irq_q <= raw_stat & irq_en;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_PEND: bus_rdata = pend_base;
      OFS_ACT:  bus_rdata = act_base;
      OFS_EN:   bus_rdata = {{(DATA_W-1){1'b0}}, irq_en};
      OFS_RAW:  bus_rdata = {{(DATA_W-1){1'b0}}, raw_stat};
      OFS_MSK:  bus_rdata = {{(DATA_W-1){1'b0}}, raw_stat & irq_en};
      default:  bus_rdata = '0;
    endcase
  end

  assign active_base = act_base;
  assign irq = irq_q;
endmodule

module fbase_shadow_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              pend_flag,
  input logic [DATA_W-1:0] pend_base,
  input logic [DATA_W-1:0] active_base,
  input logic              raw_stat,
  input logic              irq_en,
  input logic              irq
);
  // R2
  pend_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_base[1:0] == 2'b00);

  // R3
  copy_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pend_flag) |=> (active_base == $past(pend_base)));

  // R4
  hold_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && pend_flag) |=> $stable(active_base));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pend_flag) |=> raw_stat);

  // R7
  clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(5) && bus_wdata[0] && !(frame_start && pend_flag))
      |=> !raw_stat);

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat && irq_en) |=> irq);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(raw_stat && irq_en));
endmodule

bind fbase_shadow fbase_shadow_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_flag(pend_flag),
  .pend_base(pend_base), .active_base(active_base), .raw_stat(raw_stat),
  .irq_en(irq_en), .irq(irq)
);

// File: tb/test_fbase_shadow.sv
module test_fbase_shadow;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata, active_base;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] prev_exp;

  fbase_shadow #(.DATA_W(DW), .ADDR_W(AW)) i_fbase_shadow (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .active_base(active_base), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic fs, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    frame_start = fs; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    frame_start = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a), v); check("R1 reset read", v, '0);
    end
    check("R1 irq at reset", {31'b0, irq}, '0);
    cyc(1'b1, 1'b0, '0, '0);
    rd(AW'(1), v); check("R1 no pending after reset", v, '0);
    rd(AW'(3), v); check("R1 no status after reset", v, '0);

    // sweep of base values with enable on and off
    prev_exp = '0;
    for (int i = 0; i < 16; i++) begin
      logic [DW-1:0] val, exp;
      logic en;
      val = 32'h1357_9bdf * (i + 1) + i;
      exp = val & ~32'h3;
      en = i[0];
      cyc(1'b0, 1'b1, AW'(2), {31'h7fff_ffff, en});
      rd(AW'(2), v); check("R6 enable readback", v, {31'b0, en});
      cyc(1'b0, 1'b1, AW'(0), val);
      rd(AW'(0), v); check("R2 aligned pending", v, exp);
      rd(AW'(1), v); check("R3 active held before frame", v, prev_exp);
      check("R3 port held before frame", active_base, prev_exp);
      cyc(1'b1, 1'b0, '0, '0);
      rd(AW'(1), v); check("R3 active after frame", v, exp);
      check("R3 port after frame", active_base, exp);
      rd(AW'(3), v); check("R3 status set", v, 32'd1);
      rd(AW'(4), v); check("R6 masked status", v, {31'b0, en});
      idle();
      check("R9 irq follows masked", {31'b0, irq}, {31'b0, en});
      cyc(1'b1, 1'b0, '0, '0);
      rd(AW'(1), v); check("R4 second frame keeps base", v, exp);
      cyc(1'b0, 1'b1, AW'(5), '0);
      rd(AW'(3), v); check("R7 zero clear no effect", v, 32'd1);
      cyc(1'b0, 1'b1, AW'(5), 32'd1);
      rd(AW'(3), v); check("R7 clear status", v, '0);
      idle();
      check("R9 irq drops after clear", {31'b0, irq}, '0);
      cyc(1'b1, 1'b0, '0, '0);
      rd(AW'(3), v); check("R4 no status without write", v, '0);
      prev_exp = exp;
    end

    // R6 disable masks status
    cyc(1'b0, 1'b1, AW'(2), 32'd1);
    cyc(1'b0, 1'b1, AW'(0), 32'hA000_0003);
    cyc(1'b1, 1'b0, '0, '0);
    cyc(1'b0, 1'b1, AW'(2), 32'd0);
    rd(AW'(4), v); check("R6 masked zero when disabled", v, '0);
    rd(AW'(3), v); check("R6 raw still set", v, 32'd1);
    idle();
    check("R9 irq low when disabled", {31'b0, irq}, '0);
    cyc(1'b0, 1'b1, AW'(2), 32'd1);
    cyc(1'b0, 1'b1, AW'(5), 32'd1);

    // R8 set and clear in the same cycle
    cyc(1'b0, 1'b1, AW'(0), 32'hB000_0010);
    cyc(1'b1, 1'b1, AW'(5), 32'd1);
    rd(AW'(3), v); check("R8 set wins", v, 32'd1);
    rd(AW'(1), v); check("R8 base taken", v, 32'hB000_0010);
    idle();
    check("R8 irq stays", {31'b0, irq}, 32'd1);
    cyc(1'b0, 1'b1, AW'(5), 32'd1);

    // R5 pending write and frame in the same cycle
    cyc(1'b0, 1'b1, AW'(0), 32'hC000_0100);
    cyc(1'b1, 1'b1, AW'(0), 32'hD000_0202);
    rd(AW'(1), v); check("R5 old value taken", v, 32'hC000_0100);
    rd(AW'(0), v); check("R5 new value pending", v, 32'hD000_0200);
    cyc(1'b0, 1'b1, AW'(5), 32'd1);
    cyc(1'b1, 1'b0, '0, '0);
    rd(AW'(1), v); check("R5 new value taken next frame", v, 32'hD000_0200);
    rd(AW'(3), v); check("R5 status on second take", v, 32'd1);

    // R10 read-only and unmapped offsets
    cyc(1'b0, 1'b1, AW'(1), 32'h1111_1111);
    cyc(1'b0, 1'b1, AW'(3), 32'h0);
    cyc(1'b0, 1'b1, AW'(4), 32'h0);
    cyc(1'b0, 1'b1, AW'(6), 32'hFFFF_FFFF);
    cyc(1'b0, 1'b1, AW'(7), 32'hFFFF_FFFF);
    rd(AW'(1), v); check("R10 active not writable", v, 32'hD000_0200);
    rd(AW'(3), v); check("R10 status not writable", v, 32'd1);
    rd(AW'(0), v); check("R10 pending untouched", v, 32'hD000_0200);
    rd(AW'(5), v); check("R10 clear reads zero", v, '0);
    rd(AW'(6), v); check("R10 offset 6 zero", v, '0);
    rd(AW'(7), v); check("R10 offset 7 zero", v, '0);
    cyc(1'b1, 1'b0, '0, '0);
    rd(AW'(1), v); check("R10 no pending from bad writes", v, 32'hD000_0200);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule